// File: doc/BRIEF.md
# Ternary Lookup Unit with Null Propagation

This block is a purely combinational lookup element for balanced-ternary data. Each trit is carried as a 2-bit code that can stand for -1, 0, +1, or a fourth value, null, which means "no data". A small group of key trits (one to three) addresses a truth table that is fixed by a parameter. Each table entry holds either an output trit or null. A null entry marks a combination that has no result. A null anywhere in the key also yields null, whatever the table holds. The block can therefore stop a flow of data as well as compute a value.

Next to the scalar lookup, a vector section applies two fixed two-input tables at every position of a value vector, with one control trit shared by all positions. The keep-on-true output passes the vector only when the control is +1. The keep-on-false output passes it only when the control is 0. Otherwise each output is all null. The two outputs can never both carry data at the same position, so a downstream merge of the two can select one path per decision.

Top module: `tlut_unit`

## Requirements
- R1: Trit codes are 2'b00 = null, 2'b01 = 0, 2'b10 = +1, 2'b11 = -1. If any key trit is null, `look_o` is null, whatever the table holds.
- R2: With no null key trit, the key is read as a base-3 index with digits -1→0, 0→1, +1→2. Key trit 0 sits in `key_i[1:0]` and is the most significant digit. `look_o` equals the table entry at that index, and entry i sits in bits [2i+1:2i] of `TABLE`.
- R3: A table entry that holds the null code yields null at `look_o`, even when every key trit is non-null.
- R4: When `ctrl_i` is +1, `keep_t_o` equals `vec_i` at every position. Position p occupies bits [2p+1:2p].
- R5: When `ctrl_i` is 0, -1 or null, every position of `keep_t_o` is null.
- R6: When `ctrl_i` is 0, `keep_f_o` equals `vec_i`. For every other control value, including null, `keep_f_o` is all null.
- R7: A null position in `vec_i` is null in both `keep_t_o` and `keep_f_o`, for every control value. At no position are both outputs non-null at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| key_i | input | 2*NIN | Key trits for the scalar lookup; trit 0 in the low bits |
| look_o | output | 2 | Scalar lookup result |
| ctrl_i | input | 2 | Shared control trit for the vector section |
| vec_i | input | 2*WIDTH | Value vector |
| keep_t_o | output | 2*WIDTH | Vector passed when the control is +1, null otherwise |
| keep_f_o | output | 2*WIDTH | Vector passed when the control is 0, null otherwise |

## Verification
The hardest cases to reach are the combinations in which every key trit is valid but the table entry is null. Uniform random codes land on them rarely, and they must be told apart from the much more common null-key case. The stimulus therefore walks every non-null key combination once, directed, so that each missing entry is exercised. Random vectors then mix null positions into the value vector under all four control codes, which covers the interplay between null data and the control trit.

// File: rtl/tlut_unit.sv
module tlut_unit #(
  parameter int NIN = 2,
  parameter int WIDTH = 9,
  parameter logic [53:0] TABLE = {36'd0,
    2'b10, 2'b10, 2'b00,
    2'b10, 2'b01, 2'b11,
    2'b00, 2'b11, 2'b11}
) (
  input  logic [2*NIN-1:0]   key_i,
  output logic [1:0]         look_o,
  input  logic [1:0]         ctrl_i,
  input  logic [2*WIDTH-1:0] vec_i,
  output logic [2*WIDTH-1:0] keep_t_o,
  output logic [2*WIDTH-1:0] keep_f_o
);
  localparam logic [1:0] NUL = 2'b00;
  localparam logic [53:0] KEEP_T = {36'd0, 2'b10, 2'b01, 2'b11, 12'd0};
  localparam logic [53:0] KEEP_F = {42'd0, 2'b10, 2'b01, 2'b11, 6'd0};

  function automatic int digit(input logic [1:0] c);
    return (c == 2'b11) ? 0 : (c == 2'b01) ? 1 : 2;
  endfunction

  function automatic logic [1:0] lookup(input logic [53:0] tbl, input int n,
                                        input logic [5:0] keys);
    int idx;
    logic blocked;
    idx = 0;
    blocked = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (i < n) begin
        if (keys[2*i +: 2] == NUL) blocked = 1'b1;
        idx = idx * 3 + digit(keys[2*i +: 2]);
      end
    end
    return blocked ? NUL : tbl[2*idx +: 2];
  endfunction

  logic [5:0] key_ext;
  assign key_ext = 6'(key_i);
  assign look_o  = lookup(TABLE, NIN, key_ext);

  for (genvar p = 0; p < WIDTH; p++) begin : g_pos
    assign keep_t_o[2*p +: 2] = lookup(KEEP_T, 2, {2'b00, vec_i[2*p +: 2], ctrl_i});
    assign keep_f_o[2*p +: 2] = lookup(KEEP_F, 2, {2'b00, vec_i[2*p +: 2], ctrl_i});
  end
endmodule

// File: rtl/tlut_unit_chk.sv
module tlut_unit_chk #(
  parameter int NIN = 2,
  parameter int WIDTH = 9
) (
  input logic [2*NIN-1:0]   key_i,
  input logic [1:0]         look_o,
  input logic [1:0]         ctrl_i,
  input logic [2*WIDTH-1:0] vec_i,
  input logic [2*WIDTH-1:0] keep_t_o,
  input logic [2*WIDTH-1:0] keep_f_o
);
  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      if (key_i[2*i +: 2] == 2'b00)
        a_r1_null_key: assert (look_o == 2'b00);
    end
    if (ctrl_i == 2'b10)
      a_r4_true_pass: assert (keep_t_o == vec_i);
    else
      a_r5_true_block: assert (keep_t_o == '0);
    if (ctrl_i == 2'b01)
      a_r6_false_pass: assert (keep_f_o == vec_i);
    else
      a_r6_false_block: assert (keep_f_o == '0);
    for (int p = 0; p < WIDTH; p++) begin
      a_r7_exclusive: assert (keep_t_o[2*p +: 2] == 2'b00 || keep_f_o[2*p +: 2] == 2'b00);
      if (vec_i[2*p +: 2] == 2'b00)
        a_r7_null_value: assert (keep_t_o[2*p +: 2] == 2'b00 && keep_f_o[2*p +: 2] == 2'b00);
    end
  end
endmodule

bind tlut_unit tlut_unit_chk #(.NIN(NIN), .WIDTH(WIDTH)) u_chk (
  .key_i(key_i), .look_o(look_o), .ctrl_i(ctrl_i), .vec_i(vec_i),
  .keep_t_o(keep_t_o), .keep_f_o(keep_f_o));

// File: tb/tlut_unit_bench.sv
module tlut_unit_bench;
  localparam int NIN = 2;
  localparam int W = 9;
  localparam logic [53:0] TB_TBL = {36'd0,
    2'b00, 2'b10, 2'b11,
    2'b01, 2'b00, 2'b10,
    2'b11, 2'b01, 2'b00};

  logic clk = 0;
  logic rst = 1;
  always #10 clk = ~clk;

  logic [2*NIN-1:0] key;
  logic [1:0] look, ctrl;
  logic [2*W-1:0] vec, kt, kf;
  int total = 0, fails = 0;
  bit done = 0;

  tlut_unit #(.NIN(NIN), .WIDTH(W), .TABLE(TB_TBL)) u_tlut_unit (
    .key_i(key), .look_o(look), .ctrl_i(ctrl), .vec_i(vec),
    .keep_t_o(kt), .keep_f_o(kf));

  function automatic logic [1:0] exp_look(input logic [2*NIN-1:0] k);
    int idx = 0;
    for (int i = 0; i < NIN; i++) begin
      logic [1:0] c = k[2*i +: 2];
      if (c == 2'b00) return 2'b00;
      idx = idx * 3 + ((c == 2'b11) ? 0 : (c == 2'b01) ? 1 : 2);
    end
    return TB_TBL[2*idx +: 2];
  endfunction

  function automatic logic [2*W-1:0] exp_keep(input logic [1:0] c, input logic [1:0] want,
                                               input logic [2*W-1:0] v);
    return (c == want) ? v : '0;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] rnd_code();
    return 2'($urandom_range(0, 3));
  endfunction

  task automatic apply(input logic [2*NIN-1:0] k, input logic [1:0] c, input logic [2*W-1:0] v);
    @(negedge clk);
    key = k; ctrl = c; vec = v;
    #1;
    check("R1/R2/R3 look", 64'(look), 64'(exp_look(k)));
    check((c == 2'b10) ? "R4 keep_t" : "R5 keep_t", 64'(kt), 64'(exp_keep(c, 2'b10, v)));
    check("R6 keep_f", 64'(kf), 64'(exp_keep(c, 2'b01, v)));
  endtask

  initial begin
    void'($urandom(32'd5150));
    key = '0; ctrl = '0; vec = '0;
    repeat (2) @(posedge clk);
    rst = 0;
    @(negedge clk); #1;
    check("R1 reset look", 64'(look), 64'd0);
    check("R5 reset keep_t", 64'(kt), 64'd0);
    check("R6 reset keep_f", 64'(kf), 64'd0);
    // R2 R3: every non-null key, including the null entries at index 0, 4 and 8
    for (int a = 1; a < 4; a++)
      for (int b = 1; b < 4; b++)
        apply({2'(b), 2'(a)}, 2'b10, {W{2'b01}});
    // R1: null in either key position
    apply({2'b10, 2'b00}, 2'b01, {W{2'b11}});
    apply({2'b00, 2'b10}, 2'b11, {W{2'b10}});
    // R7: vector with null positions under every control code
    for (int c = 0; c < 4; c++) begin
      logic [2*W-1:0] v = {2'b00, 2'b10, 2'b00, 2'b11, 2'b01, 2'b00, 2'b10, 2'b11, 2'b00};
      apply({2'b01, 2'b01}, 2'(c), v);
      for (int p = 0; p < W; p++)
        if (v[2*p +: 2] == 2'b00)
          check("R7 null pos", 64'({kt[2*p +: 2], kf[2*p +: 2]}), 64'd0);
    end
    for (int n = 0; n < 400; n++) begin
      logic [2*W-1:0] v;
      for (int p = 0; p < W; p++) v[2*p +: 2] = rnd_code();
      apply({rnd_code(), rnd_code()}, rnd_code(), v);
      for (int p = 0; p < W; p++)
        if (kt[2*p +: 2] != 2'b00 && kf[2*p +: 2] != 2'b00)
          check("R7 exclusive", 64'({kt[2*p +: 2], kf[2*p +: 2]}), 64'd0);
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule